// File: doc/BRIEF.md
# Protected Program-Memory Programming Controller

This block is the control side of a byte-wide on-chip program store while the chip sits in its programming mode. A three-bit operation code selects one of six actions: write a code byte, read a code byte back, write one entry of a 32-entry scrambling key, set protection bit A, set protection bit B, or read a fixed identification byte. The store itself is a small behavioural array inside the block.

Writes are not single strobes. The programmer applies a train of program pulses while the high-voltage enable is held. The block counts them and commits the write only once the count required for that operation is reached. Code bytes need 5 pulses; key entries and protection bits need 25.

Read-back of code is never plain. Each byte is XNORed with the key entry picked by the five low address bits, so an erased key returns the code unchanged. The two protection bits act in stages. Bit A freezes the code and the key. It also blocks table reads issued from external code and freezes the external-access strap at its value during reset. With both bits set, read-back is refused as well. The protection bits cannot be read; only their effects can be seen. An erase input returns the code, the key and both protection bits to all ones.

Top module: `prom_guard`

## Requirements
- R1: The 16-bit programming address is {addr_hi[1:0], addr_mid[5:0], addr_lo[7:0]}, with addr_lo holding bits 7..0.
- R2: op_sel encodes 1 = write code, 2 = read code, 3 = write key, 4 = set bit A, 5 = set bit B, 6 = identification read, and 0 or 7 = idle. Out of reset, and whenever the op_sel sampled at the previous edge was not 2 or 6, dout is FFh and dout_vld is 0.
- R3: A rising edge of prog_strobe is counted only while hv_en is high and the selected write is permitted. A code byte is stored on the 5th counted edge.
- R4: A key entry or a protection bit is set on the 25th counted edge, and 24 edges leave it untouched. After a commit the count saturates, so later edges with different din store nothing.
- R5: The pulse count clears whenever op_sel or the address differs from its value at the previous clock edge.
- R6: Once bit A is set, code and key writes are ignored. Setting either protection bit stays possible in every state.
- R7: In read-code mode, dout one cycle later equals the code byte XNOR key[addr[4:0]], with dout_vld high. If both protection bits are set, dout is FFh instead. Bit B alone changes nothing.
- R8: In identification mode, dout one cycle later is 89h at address 0030h, 58h at 0031h, FBh at 0060h, and FFh at every other address.
- R9: While bit A is clear, ea_eff follows ea_pin. While bit A is set, ea_eff holds the ea_pin value sampled during the last reset.
- R10: tbl_data one cycle later is the unscrambled code byte at tbl_addr. It is FFh when bit A is set and tbl_ext is high.
- R11: While erase is high, the code array, the key and both protection bits become all ones at the next edge.
- R12: Addresses at or above 2^MEM_AW hold no code. Writes to them are ignored, and they read as FFh before the XNOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the volatile state |
| op_sel | input | 3 | Operation code |
| addr_lo | input | 8 | Address bits 7..0 |
| addr_mid | input | 6 | Address bits 13..8 |
| addr_hi | input | 2 | Address bits 15..14 |
| din | input | 8 | Byte to write |
| hv_en | input | 1 | Programming-voltage enable, gates pulse counting |
| prog_strobe | input | 1 | Program pulse; rising edges are counted |
| erase | input | 1 | Return all stored state to ones |
| dout | output | 8 | Read-back or identification byte |
| dout_vld | output | 1 | High one cycle after a read operation is selected |
| ea_pin | input | 1 | External-access strap |
| ea_eff | output | 1 | External-access value seen by the core |
| tbl_ext | input | 1 | Table read issued from external code |
| tbl_addr | input | 16 | Table read address |
| tbl_data | output | 8 | Table read byte |

## Verification
The bench writes and reads back the whole small array, first under an erased key and then under a fully programmed key. The expected bytes are computed arithmetically, so a wrong key index or a plain XOR shows up as mismatching bytes. Pulse counting is tested at its edges: 4 valid pulses, pulses with the high voltage off, an address change in the middle of a train, 24 pulses for a key entry, and more pulses with new data after a commit. A design that commits early, counts without the enable, misses the count clear, or rewrites after saturation corrupts a byte that the bench then reads back. The protection stages are walked through as bit B alone, bit A alone and both together, each followed by an erase. A design that confuses the stages lets a frozen write through, returns plain data when read-back should be refused, or lets the external-access value follow the strap when it should hold.

// File: rtl/prom_guard.sv
module prom_guard #(
  parameter int MEM_AW      = 8,
  parameter int KEY_AW      = 5,
  parameter int CODE_PULSES = 5,
  parameter int AUX_PULSES  = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  op_sel,
  input  logic [7:0]  addr_lo,
  input  logic [5:0]  addr_mid,
  input  logic [1:0]  addr_hi,
  input  logic [7:0]  din,
  input  logic        hv_en,
  input  logic        prog_strobe,
  input  logic        erase,
  output logic [7:0]  dout,
  output logic        dout_vld,
  input  logic        ea_pin,
  output logic        ea_eff,
  input  logic        tbl_ext,
  input  logic [15:0] tbl_addr,
  output logic [7:0]  tbl_data
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int KEYS  = 1 << KEY_AW;
  localparam int CW    = $clog2(AUX_PULSES + 1);
  localparam logic [2:0] OP_PCODE = 3'd1, OP_VFY = 3'd2, OP_PKEY = 3'd3,
                         OP_PLKA  = 3'd4, OP_PLKB = 3'd5, OP_SIG = 3'd6;

  logic [DEPTH*8-1:0] mem_v;
  logic [KEYS*8-1:0]  key_v;
  logic               lka_n, lkb_n;

  logic [15:0] addr;
  assign addr = {addr_hi, addr_mid, addr_lo};

  logic [MEM_AW-1:0] ma;
  logic [KEY_AW-1:0] ka;
  logic              in_rng;
  logic [7:0]        code_rd, key_rd;
  assign ma      = addr[MEM_AW-1:0];
  assign ka      = addr[KEY_AW-1:0];
  assign in_rng  = (addr >> MEM_AW) == 16'd0;
  assign code_rd = in_rng ? mem_v[{ma, 3'b000} +: 8] : 8'hFF;
  assign key_rd  = key_v[{ka, 3'b000} +: 8];

  logic [MEM_AW-1:0] ta;
  logic              t_rng;
  logic [7:0]        tbl_rd;
  assign ta     = tbl_addr[MEM_AW-1:0];
  assign t_rng  = (tbl_addr >> MEM_AW) == 16'd0;
  assign tbl_rd = t_rng ? mem_v[{ta, 3'b000} +: 8] : 8'hFF;

  logic [18:0]   tag_q;
  logic          strobe_q;
  logic [CW-1:0] cnt;
  logic          changed, rise, prog_ok, counting, commit;
  logic [CW-1:0] last;

  assign changed = {op_sel, addr} != tag_q;
  assign rise    = prog_strobe & ~strobe_q;

  always_comb begin
    prog_ok = 1'b0;
    last    = CW'(AUX_PULSES - 1);
    case (op_sel)
      OP_PCODE: begin
        prog_ok = lka_n & in_rng;
        last    = CW'(CODE_PULSES - 1);
      end
      OP_PKEY:          prog_ok = lka_n;
      OP_PLKA, OP_PLKB: prog_ok = 1'b1;
      default:          prog_ok = 1'b0;
    endcase
  end

  assign counting = rst_n & rise & hv_en & prog_ok & ~changed;
  assign commit   = counting & (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q    <= '0;
      strobe_q <= 1'b0;
      cnt      <= '0;
    end else begin
      tag_q    <= {op_sel, addr};
      strobe_q <= prog_strobe;
      if (changed)
        cnt <= '0;
      else if (counting && cnt <= last)
        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (erase) begin
      mem_v <= '1;
      key_v <= '1;
      lka_n <= 1'b1;
      lkb_n <= 1'b1;
    end else if (commit) begin
      case (op_sel)
        OP_PCODE: mem_v[{ma, 3'b000} +: 8] <= din;
        OP_PKEY:  key_v[{ka, 3'b000} +: 8] <= din;
        OP_PLKA:  lka_n <= 1'b0;
        OP_PLKB:  lkb_n <= 1'b0;
        default:  ;
      endcase
    end
  end

  logic [7:0] sig_byte;
  always_comb begin
    case (addr)
      16'h0030: sig_byte = 8'h89;
      16'h0031: sig_byte = 8'h58;
      16'h0060: sig_byte = 8'hFB;
      default:  sig_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout     <= 8'hFF;
      dout_vld <= 1'b0;
      tbl_data <= 8'hFF;
    end else begin
      dout_vld <= (op_sel == OP_VFY) || (op_sel == OP_SIG);
      if (op_sel == OP_VFY)
        dout <= (!lka_n && !lkb_n) ? 8'hFF : (code_rd ~^ key_rd);
      else if (op_sel == OP_SIG)
        dout <= sig_byte;
      else
        dout <= 8'hFF;
      tbl_data <= (!lka_n && tbl_ext) ? 8'hFF : tbl_rd;
    end
  end

  logic ea_hold;
  always_ff @(posedge clk) begin
    if (!rst_n) ea_hold <= ea_pin;
  end
  assign ea_eff = lka_n ? ea_pin : ea_hold;

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(AUX_PULSES));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lka_n && !erase) |=> ($stable(key_v) && $stable(mem_v)));

  p_vfy_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_VFY && !lka_n && !lkb_n) |=> dout == 8'hFF);

  p_sig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_SIG && addr == 16'h0030) |=> dout == 8'h89);

  p_ea_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lka_n && $past(!lka_n)) |-> $stable(ea_eff));

  p_erase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (lka_n && lkb_n && (&key_v) && (&mem_v)));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel != OP_VFY && op_sel != OP_SIG) |=> (!dout_vld && dout == 8'hFF));
endmodule

// File: tb/prom_guard_bench.sv
`timescale 1ns/1ps
module prom_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [15:0] a_drv = 16'd0;
  logic [7:0]  din = 8'd0;
  logic        hv_en = 1'b0, prog_strobe = 1'b0, erase = 1'b0;
  logic        ea_pin = 1'b0, tbl_ext = 1'b0;
  logic [15:0] tbl_addr = 16'd0;
  logic [7:0]  dout, tbl_data;
  logic        dout_vld, ea_eff;

  always #2.5 clk = ~clk;

  prom_guard u_prom_guard (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel),
    .addr_lo(a_drv[7:0]), .addr_mid(a_drv[13:8]), .addr_hi(a_drv[15:14]),
    .din(din), .hv_en(hv_en), .prog_strobe(prog_strobe), .erase(erase),
    .dout(dout), .dout_vld(dout_vld), .ea_pin(ea_pin), .ea_eff(ea_eff),
    .tbl_ext(tbl_ext), .tbl_addr(tbl_addr), .tbl_data(tbl_data));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] em [256];
  logic [7:0] ek [32];

  function automatic logic [7:0] fa(int a); return 8'((a * 7 + 3) & 255); endfunction
  function automatic logic [7:0] fk(int k); return 8'((k * 13 + 5) & 255); endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup(logic [2:0] op, logic [15:0] a, logic [7:0] d);
    @(negedge clk); op_sel = op; a_drv = a; din = d;
    @(negedge clk);
  endtask

  task automatic pulses(int n, logic hv);
    hv_en = hv;
    for (int i = 0; i < n; i++) begin
      prog_strobe = 1'b1; @(negedge clk);
      prog_strobe = 1'b0; @(negedge clk);
    end
    hv_en = 1'b0;
  endtask

  task automatic wr(logic [2:0] op, logic [15:0] a, logic [7:0] d, int n);
    setup(op, a, d); pulses(n, 1'b1);
  endtask

  task automatic rd(logic [2:0] op, logic [15:0] a, output logic [7:0] v);
    @(negedge clk); op_sel = op; a_drv = a;
    @(negedge clk); v = dout;
  endtask

  task automatic trd(logic [15:0] a, logic ext, output logic [7:0] v);
    @(negedge clk); tbl_addr = a; tbl_ext = ext;
    @(negedge clk); v = tbl_data;
  endtask

  task automatic do_erase();
    @(negedge clk); erase = 1'b1; @(negedge clk); erase = 1'b0;
    for (int i = 0; i < 256; i++) em[i] = 8'hFF;
    for (int i = 0; i < 32; i++) ek[i] = 8'hFF;
  endtask

  task automatic pulse_reset(logic ea);
    @(negedge clk); ea_pin = ea; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
  endtask

  function automatic logic [7:0] enc(int a);
    return em[a] ~^ ek[a % 32];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    erase = 1'b1;
    repeat (3) @(negedge clk);
    erase = 1'b0; rst_n = 1'b1;
    for (int i = 0; i < 256; i++) em[i] = 8'hFF;
    for (int i = 0; i < 32; i++) ek[i] = 8'hFF;
    @(negedge clk);
    chk("R2 reset dout", {8'h0, dout}, 16'h00FF);
    chk("R2 reset vld", {15'h0, dout_vld}, 16'h0);
    rd(3'd2, 16'h0000, v); chk("R11 erased start", {8'h0, v}, 16'h00FF);
    chk("R2 vld on read", {15'h0, dout_vld}, 16'h1);
    @(negedge clk); op_sel = 3'd0; @(negedge clk);
    chk("R2 idle dout", {8'h0, dout}, 16'h00FF);
    chk("R2 idle vld", {15'h0, dout_vld}, 16'h0);

    for (int a = 0; a < 256; a++) begin
      wr(3'd1, 16'(a), fa(a), 5); em[a] = fa(a);
    end
    for (int a = 0; a < 256; a++) begin
      rd(3'd2, 16'(a), v); chk("R3 R7 R1 raw read", {8'h0, v}, {8'h0, em[a]});
    end

    setup(3'd1, 16'h0010, 8'h00); pulses(2, 1'b0); pulses(4, 1'b1);
    rd(3'd2, 16'h0010, v); chk("R3 4 pulses no write", {8'h0, v}, {8'h0, em[16]});
    setup(3'd1, 16'h0010, 8'h00); pulses(2, 1'b0); pulses(5, 1'b1); em[16] = 8'h00;
    rd(3'd2, 16'h0010, v); chk("R3 5th pulse writes", {8'h0, v}, 16'h0000);

    setup(3'd1, 16'h0011, 8'h00); pulses(3, 1'b1);
    @(negedge clk); a_drv = 16'h0012; @(negedge clk); a_drv = 16'h0011; @(negedge clk);
    pulses(4, 1'b1);
    rd(3'd2, 16'h0011, v); chk("R5 count cleared", {8'h0, v}, {8'h0, em[17]});
    rd(3'd2, 16'h0012, v); chk("R5 other addr", {8'h0, v}, {8'h0, em[18]});

    setup(3'd1, 16'h0013, 8'h5A); pulses(5, 1'b1);
    din = 8'hC3; pulses(20, 1'b1); em[19] = 8'h5A;
    rd(3'd2, 16'h0013, v); chk("R4 saturate", {8'h0, v}, 16'h005A);

    wr(3'd3, 16'h0000, 8'h00, 24);
    rd(3'd2, 16'h0000, v); chk("R4 24 key pulses", {8'h0, v}, {8'h0, em[0]});
    for (int k = 0; k < 32; k++) begin
      wr(3'd3, 16'(k), fk(k), 25); ek[k] = fk(k);
    end
    for (int a = 0; a < 256; a++) begin
      rd(3'd2, 16'(a), v); chk("R7 scrambled read", {8'h0, v}, {8'h0, enc(a)});
    end

    wr(3'd1, 16'h1234, 8'h00, 5);
    rd(3'd2, 16'h1234, v); chk("R12 out of range", {8'h0, v}, {8'h0, 8'hFF ~^ ek[20]});
    rd(3'd2, 16'h0034, v); chk("R12 alias untouched", {8'h0, v}, {8'h0, enc(52)});
    rd(3'd2, 16'h4101, v); chk("R1 R12 high bits", {8'h0, v}, {8'h0, 8'hFF ~^ ek[1]});

    rd(3'd6, 16'h0030, v); chk("R8 sig 30", {8'h0, v}, 16'h0089);
    rd(3'd6, 16'h0031, v); chk("R8 sig 31", {8'h0, v}, 16'h0058);
    rd(3'd6, 16'h0060, v); chk("R8 sig 60", {8'h0, v}, 16'h00FB);
    chk("R8 vld", {15'h0, dout_vld}, 16'h1);
    rd(3'd6, 16'h0032, v); chk("R8 sig other", {8'h0, v}, 16'h00FF);
    rd(3'd6, 16'h1030, v); chk("R8 sig high", {8'h0, v}, 16'h00FF);

    trd(16'h0022, 1'b0, v); chk("R10 table int", {8'h0, v}, {8'h0, em[34]});
    trd(16'h0022, 1'b1, v); chk("R10 table ext open", {8'h0, v}, {8'h0, em[34]});
    ea_pin = 1'b1; #1 chk("R9 follow 1", {15'h0, ea_eff}, 16'h1);
    ea_pin = 1'b0; #1 chk("R9 follow 0", {15'h0, ea_eff}, 16'h0);

    wr(3'd5, 16'h0000, 8'h00, 25);
    rd(3'd2, 16'h0005, v); chk("R7 bit B only", {8'h0, v}, {8'h0, enc(5)});
    wr(3'd1, 16'h0040, 8'h3C, 5); em[64] = 8'h3C;
    rd(3'd2, 16'h0040, v); chk("R6 bit B only writes", {8'h0, v}, {8'h0, enc(64)});

    do_erase();
    rd(3'd2, 16'h0040, v); chk("R11 erase code", {8'h0, v}, 16'h00FF);
    wr(3'd1, 16'h0041, 8'h77, 5); em[65] = 8'h77;
    wr(3'd4, 16'h0000, 8'h00, 24);
    wr(3'd1, 16'h0042, 8'h11, 5); em[66] = 8'h11;
    rd(3'd2, 16'h0042, v); chk("R4 bit A needs 25", {8'h0, v}, 16'h0011);
    wr(3'd4, 16'h0000, 8'h00, 25);
    wr(3'd1, 16'h0041, 8'h00, 5);
    rd(3'd2, 16'h0041, v); chk("R6 code frozen", {8'h0, v}, 16'h0077);
    wr(3'd3, 16'h0001, 8'h00, 25);
    rd(3'd2, 16'h0041, v); chk("R6 key frozen", {8'h0, v}, 16'h0077);
    trd(16'h0041, 1'b1, v); chk("R10 table ext blocked", {8'h0, v}, 16'h00FF);
    trd(16'h0041, 1'b0, v); chk("R10 table int locked", {8'h0, v}, 16'h0077);

    pulse_reset(1'b1);
    ea_pin = 1'b0; #1 chk("R9 held 1", {15'h0, ea_eff}, 16'h1);
    pulse_reset(1'b0);
    ea_pin = 1'b1; #1 chk("R9 held 0", {15'h0, ea_eff}, 16'h0);

    wr(3'd5, 16'h0000, 8'h00, 25);
    rd(3'd2, 16'h0041, v); chk("R7 both bits refuse", {8'h0, v}, 16'h00FF);
    rd(3'd6, 16'h0031, v); chk("R8 sig when locked", {8'h0, v}, 16'h0058);

    do_erase();
    rd(3'd2, 16'h0041, v); chk("R11 erase unlock read", {8'h0, v}, 16'h00FF);
    ea_pin = 1'b0; #1 chk("R11 R9 follow after erase", {15'h0, ea_eff}, 16'h0);
    wr(3'd1, 16'h0041, 8'h24, 5);
    rd(3'd2, 16'h0041, v); chk("R11 writes again", {8'h0, v}, 16'h0024);
    trd(16'h0041, 1'b1, v); chk("R11 table ext open", {8'h0, v}, 16'h0024);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule